// File: doc/BRIEF.md
# PHY status LED driver

This block drives the two status LEDs of an Ethernet PHY. Each LED has its own 4-bit mode code. The code picks what the LED shows: a single kind of traffic activity, the link or duplex state, a fixed level, one of two blink rates, or a status level combined with activity. The PHY supplies transmit, receive and collision events as one-cycle strobes, and link-up and full-duplex as levels.

A shared 2-bit select picks a short, medium or long stretch time, and a shared enable turns stretching on for the single-activity modes. The combined modes stretch their activity in every case. Each LED has its own stretch counter, and both LEDs share one blink timebase. All times are parameters counted in clock cycles. Each LED output is a register, so every result shows at the clock edge after the edge that sampled its cause.

Top module: `phy_led_driver`

## Requirements
- R1: The single-activity modes respond only to their own event. Mode 0001 responds to transmit, 0010 to receive, 0011 to collision, and 0111 to transmit or receive. An event of any other kind leaves the LED dark.
- R2: Mode 1000 holds the LED lit and mode 1001 holds it dark. Mode 1010 toggles the LED every BLINK_FAST_HALF cycles and mode 1011 toggles it every BLINK_SLOW_HALF cycles.
- R3: Mode 0100 shows link_up and mode 0101 shows full_duplex. The LED follows its input one cycle after the input changes.
- R4: The reserved codes 0000, 0110 and 1111 keep the LED dark whatever the events do.
- R5: With stretch_en low, a single-activity LED is lit only in the one cycle after the strobe is sampled.
- R6: With stretch_en high, a strobe lights a single-activity LED for D cycles, starting in the cycle after the strobe. D is STRETCH_SHORT for select 00, STRETCH_MEDIUM for 01 and STRETCH_LONG for 10.
- R7: Stretch select 11 gives the same duration as 00.
- R8: A new qualifying event during a stretch reloads the full duration, counted from the new event.
- R9: The combined modes stretch their activity even when stretch_en is low. Mode 1100 uses link with receive, 1101 uses link with transmit or receive, and 1110 uses duplex with collision. When the status is true the LED is lit and a stretched pulse turns it dark. When the status is false a stretched pulse lights it.
- R10: A change of mode code takes effect one cycle later and discards any stretch in progress on that LED.
- R11: While rst_n is low at a clock edge, both LEDs go dark in the next cycle and all counters clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| led_a_mode | input | 4 | Mode code for LED A |
| led_b_mode | input | 4 | Mode code for LED B |
| stretch_sel | input | 2 | Stretch duration select (00 short, 01 medium, 10 long, 11 short) |
| stretch_en | input | 1 | Enables stretching for the single-activity modes |
| tx_evt | input | 1 | One-cycle transmit event strobe |
| rx_evt | input | 1 | One-cycle receive event strobe |
| col_evt | input | 1 | One-cycle collision event strobe |
| link_up | input | 1 | Link status level |
| full_duplex | input | 1 | Duplex status level |
| led_a | output | 1 | LED A drive, high means lit |
| led_b | output | 1 | LED B drive, high means lit |

## Verification
Every result appears at the first clock edge after the edge that samples its cause. A strobe driven before edge n+1 lights the LED at edge n+1 and, when stretched for D cycles, keeps it lit through edge n+D, so the LED is dark again at edge n+D+1. For each stimulus the driver queues the expected level of each LED against these exact edge numbers. The monitor samples 2 ns after each rising edge and compares only the entries due at that edge. Blink rates are checked separately, by measuring the number of cycles between successive output toggles.

// File: rtl/phy_led_pkg.sv
`timescale 1ns/1ps
// Shared mode codes and decode helpers for the PHY status LED driver.
// Assumes mode codes are 4 bits wide; the numeric values select behaviour.
package phy_led_pkg;

    typedef enum logic [3:0] {
        MD_RSV_LO     = 4'h0,
        MD_TX         = 4'h1,
        MD_RX         = 4'h2,
        MD_COL        = 4'h3,
        MD_LINK       = 4'h4,
        MD_DUPLEX     = 4'h5,
        MD_RSV_MID    = 4'h6,
        MD_TXRX       = 4'h7,
        MD_ON         = 4'h8,
        MD_OFF        = 4'h9,
        MD_BLINK_FAST = 4'hA,
        MD_BLINK_SLOW = 4'hB,
        MD_LINK_RX    = 4'hC,
        MD_LINK_TXRX  = 4'hD,
        MD_DUP_COL    = 4'hE,
        MD_RSV_HI     = 4'hF
    } led_mode_e;

    localparam int NUM_LEDS = 2;

    // Activity relevant to a mode, built from the event strobes.
    function automatic logic mode_activity(input logic [3:0] md, input logic tx,
                                           input logic rx, input logic col);
        case (md)
            MD_TX:                   return tx;
            MD_RX, MD_LINK_RX:       return rx;
            MD_COL, MD_DUP_COL:      return col;
            MD_TXRX, MD_LINK_TXRX:   return tx | rx;
            default:                 return 1'b0;
        endcase
    endfunction

    // Modes whose stretching depends on the enable bit.
    function automatic logic mode_stretchable(input logic [3:0] md);
        return (md == MD_TX) || (md == MD_RX) || (md == MD_COL) || (md == MD_TXRX);
    endfunction

    // Modes that stretch regardless of the enable bit.
    function automatic logic mode_combined(input logic [3:0] md);
        return (md == MD_LINK_RX) || (md == MD_LINK_TXRX) || (md == MD_DUP_COL);
    endfunction

endpackage

// File: rtl/led_toggle_gen.sv
`timescale 1ns/1ps
// Free-running square wave: the phase output flips every HALF_CYC clocks.
// Assumes HALF_CYC >= 1. Phase starts low after reset.
module led_toggle_gen #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] WRAP = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    // Count one half period, then flip the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == WRAP) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: the phase never changes mid-half-period.
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != WRAP) |=> $stable(phase));

endmodule

// File: rtl/led_stretch_timer.sv
`timescale 1ns/1ps
// Per-LED stretch counter. Decodes the activity for the current mode, loads
// the selected duration (minus one) on a qualifying event, counts down, and
// clears when the mode code changes. Assumes all durations are >= 1.
module led_stretch_timer
    import phy_led_pkg::*;
#(
    parameter int STRETCH_SHORT  = 3,
    parameter int STRETCH_MEDIUM = 5,
    parameter int STRETCH_LONG   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode,
    input  logic [1:0] sel,
    input  logic       stretch_en,
    input  logic       tx,
    input  logic       rx,
    input  logic       col,
    output logic       act,
    output logic       busy
);
    localparam int MAXD = (STRETCH_LONG > STRETCH_MEDIUM) ?
                          ((STRETCH_LONG > STRETCH_SHORT) ? STRETCH_LONG : STRETCH_SHORT) :
                          ((STRETCH_MEDIUM > STRETCH_SHORT) ? STRETCH_MEDIUM : STRETCH_SHORT);
    localparam int CW = $clog2(MAXD + 1);
    localparam logic [CW-1:0] LD_S = CW'(STRETCH_SHORT - 1);
    localparam logic [CW-1:0] LD_M = CW'(STRETCH_MEDIUM - 1);
    localparam logic [CW-1:0] LD_L = CW'(STRETCH_LONG - 1);
    localparam logic [CW-1:0] LD_MAX = CW'(MAXD - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;
    logic [3:0]    mode_q;
    logic          mode_chg;
    logic          arm;

    // Select the reload value; the reserved select falls back to short.
    always_comb begin
        case (sel)
            2'b01:   load_val = LD_M;
            2'b10:   load_val = LD_L;
            default: load_val = LD_S;
        endcase
    end

    // Decode whether the current event should start or restart a stretch.
    always_comb begin
        act      = mode_activity(mode, tx, rx, col);
        mode_chg = (mode != mode_q);
        arm      = act && (mode_combined(mode) || (mode_stretchable(mode) && stretch_en));
        busy     = (cnt != '0) && !mode_chg;
    end

    // Track the last mode and run the countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            mode_q <= '0;
        end else begin
            mode_q <= mode;
            if (mode_chg)
                cnt <= '0;
            else if (arm)
                cnt <= load_val;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // R6: the counter never exceeds the longest configured load.
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LD_MAX);

    // R10: a mode change leaves no stretch behind.
    p_clear_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != mode_q) |=> (cnt == '0));

endmodule

// File: rtl/led_output_sel.sv
`timescale 1ns/1ps
// Chooses the next LED level from the mode code and registers it.
// Assumes act/busy come from the matching stretch timer and the blink
// phases from the shared timebase.
module led_output_sel
    import phy_led_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode,
    input  logic       act,
    input  logic       busy,
    input  logic       stretch_en,
    input  logic       link_up,
    input  logic       full_duplex,
    input  logic       fast_ph,
    input  logic       slow_ph,
    output logic       led
);
    logic nxt;
    logic pulse;

    // Pick the level the LED should show for the current mode.
    always_comb begin
        pulse = act | busy;
        case (mode)
            MD_TX, MD_RX, MD_COL, MD_TXRX: nxt = act | (busy & stretch_en);
            MD_LINK:                       nxt = link_up;
            MD_DUPLEX:                     nxt = full_duplex;
            MD_ON:                         nxt = 1'b1;
            MD_OFF:                        nxt = 1'b0;
            MD_BLINK_FAST:                 nxt = fast_ph;
            MD_BLINK_SLOW:                 nxt = slow_ph;
            MD_LINK_RX, MD_LINK_TXRX:      nxt = link_up ? ~pulse : pulse;
            MD_DUP_COL:                    nxt = full_duplex ? ~pulse : pulse;
            default:                       nxt = 1'b0;
        endcase
    end

    // Register the LED level.
    always_ff @(posedge clk) begin
        if (!rst_n) led <= 1'b0;
        else        led <= nxt;
    end

    // R2: steady modes.
    p_steady_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_ON) |=> led);
    p_steady_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_OFF) |=> !led);

    // R4: reserved codes stay dark.
    p_reserved_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RSV_LO || mode == MD_RSV_MID || mode == MD_RSV_HI) |=> !led);

endmodule

// File: rtl/phy_led_driver.sv
`timescale 1ns/1ps
// Two-LED PHY status driver. A shared timebase supplies the blink phases;
// each LED has its own stretch timer and output selector.
// Assumes event inputs are synchronous single-cycle strobes.
module phy_led_driver
    import phy_led_pkg::*;
#(
    parameter int STRETCH_SHORT   = 5000000,
    parameter int STRETCH_MEDIUM  = 8750000,
    parameter int STRETCH_LONG    = 17500000,
    parameter int BLINK_FAST_HALF = 6250000,
    parameter int BLINK_SLOW_HALF = 25000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] led_a_mode,
    input  logic [3:0] led_b_mode,
    input  logic [1:0] stretch_sel,
    input  logic       stretch_en,
    input  logic       tx_evt,
    input  logic       rx_evt,
    input  logic       col_evt,
    input  logic       link_up,
    input  logic       full_duplex,
    output logic       led_a,
    output logic       led_b
);
    logic                fast_ph;
    logic                slow_ph;
    logic [3:0]          mode_v [NUM_LEDS];
    logic [NUM_LEDS-1:0] act_v;
    logic [NUM_LEDS-1:0] busy_v;
    logic [NUM_LEDS-1:0] led_v;

    // Gather the per-LED mode codes into an array.
    always_comb begin
        mode_v[0] = led_a_mode;
        mode_v[1] = led_b_mode;
    end

    led_toggle_gen #(.HALF_CYC(BLINK_FAST_HALF)) u_fast (
        .clk(clk), .rst_n(rst_n), .phase(fast_ph));
    led_toggle_gen #(.HALF_CYC(BLINK_SLOW_HALF)) u_slow (
        .clk(clk), .rst_n(rst_n), .phase(slow_ph));

    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led
        led_stretch_timer #(
            .STRETCH_SHORT(STRETCH_SHORT),
            .STRETCH_MEDIUM(STRETCH_MEDIUM),
            .STRETCH_LONG(STRETCH_LONG)
        ) u_timer (
            .clk(clk), .rst_n(rst_n), .mode(mode_v[g]), .sel(stretch_sel),
            .stretch_en(stretch_en), .tx(tx_evt), .rx(rx_evt), .col(col_evt),
            .act(act_v[g]), .busy(busy_v[g]));

        led_output_sel u_sel (
            .clk(clk), .rst_n(rst_n), .mode(mode_v[g]), .act(act_v[g]),
            .busy(busy_v[g]), .stretch_en(stretch_en), .link_up(link_up),
            .full_duplex(full_duplex), .fast_ph(fast_ph), .slow_ph(slow_ph),
            .led(led_v[g]));
    end

    assign led_a = led_v[0];
    assign led_b = led_v[1];

    // R11: reset darkens both LEDs on the next cycle.
    p_reset_off_r11: assert property (@(posedge clk)
        !rst_n |=> (!led_a && !led_b));

    // R5: without stretching, a transmit-activity LED mirrors the strobe.
    p_plain_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (led_a_mode == 4'h1 && !stretch_en) |=> (led_a == $past(tx_evt)));

endmodule

// File: tb/phy_led_driver_bench.sv
`timescale 1ns/1ps
module phy_led_driver_bench;
    localparam int T_S = 3, T_M = 5, T_L = 8, H_F = 4, H_S = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [3:0] led_a_mode = 4'h0, led_b_mode = 4'h0;
    logic [1:0] stretch_sel = 2'b00;
    logic stretch_en = 1'b0, tx_evt = 1'b0, rx_evt = 1'b0, col_evt = 1'b0;
    logic link_up = 1'b0, full_duplex = 1'b0;
    logic led_a, led_b;

    phy_led_driver #(
        .STRETCH_SHORT(T_S), .STRETCH_MEDIUM(T_M), .STRETCH_LONG(T_L),
        .BLINK_FAST_HALF(H_F), .BLINK_SLOW_HALF(H_S)
    ) u_phy_led_driver (
        .clk(clk), .rst_n(rst_n), .led_a_mode(led_a_mode), .led_b_mode(led_b_mode),
        .stretch_sel(stretch_sel), .stretch_en(stretch_en), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .col_evt(col_evt), .link_up(link_up),
        .full_duplex(full_duplex), .led_a(led_a), .led_b(led_b));

    always #4 clk = ~clk;

    typedef struct {
        int    cyc;
        int    idx;
        bit    val;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int cyc = 0, n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    function automatic logic get_led(int idx);
        return (idx == 0) ? led_a : led_b;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, expv);
        end
    endtask

    // Queue expected LED levels for cycles cyc+from .. cyc+to.
    task automatic expect_run(int from, int to, int idx, bit v, string req);
        for (int k = from; k <= to; k++) exp_q.push_back('{cyc + k, idx, v, req});
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle strobe: bit0 tx, bit1 rx, bit2 col.
    task automatic pulse(logic [2:0] m);
        tx_evt = m[0]; rx_evt = m[1]; col_evt = m[2];
        @(negedge clk);
        tx_evt = 1'b0; rx_evt = 1'b0; col_evt = 1'b0;
    endtask

    // Measure two intervals between output toggles.
    task automatic measure_blink(int idx, int half, string req);
        logic prv;
        int   t0, seen;
        prv = get_led(idx); t0 = -1; seen = 0;
        for (int k = 0; k < 8 * half && seen < 3; k++) begin
            @(negedge clk);
            if (get_led(idx) != prv) begin
                prv = get_led(idx);
                if (t0 >= 0) chk((cyc - t0) == half, req, cyc - t0, half);
                t0 = cyc;
                seen++;
            end
        end
        chk(seen == 3, req, seen, 3);
    endtask

    // Monitor: pop expectations due at this edge and compare.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            for (int i = exp_q.size() - 1; i >= 0; i--) begin
                if (exp_q[i].cyc == cyc) begin
                    chk(get_led(exp_q[i].idx) == exp_q[i].val, exp_q[i].req,
                        int'(get_led(exp_q[i].idx)), int'(exp_q[i].val));
                    exp_q.delete(i);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Driver.
    initial begin
        step(3);
        chk(!led_a && !led_b, "R11", int'(led_a | led_b), 0);   // R11 reset state
        rst_n = 1'b1;

        // R2 steady levels
        led_a_mode = 4'h8; led_b_mode = 4'h9;
        expect_run(1, 2, 0, 1'b1, "R2"); expect_run(1, 2, 1, 1'b0, "R2");
        step(3);

        // R3 status following
        led_a_mode = 4'h4; led_b_mode = 4'h5; link_up = 1'b1; full_duplex = 1'b0;
        expect_run(1, 1, 0, 1'b1, "R3"); expect_run(1, 1, 1, 1'b0, "R3");
        step(2);
        link_up = 1'b0; full_duplex = 1'b1;
        expect_run(1, 1, 0, 1'b0, "R3"); expect_run(1, 1, 1, 1'b1, "R3");
        step(2);

        // R4 reserved codes
        stretch_en = 1'b1;
        led_a_mode = 4'h0; led_b_mode = 4'h6;
        step(2);
        expect_run(1, 4, 0, 1'b0, "R4"); expect_run(1, 4, 1, 1'b0, "R4");
        pulse(3'b111); step(4);
        led_a_mode = 4'hF;
        step(2);
        expect_run(1, 4, 0, 1'b0, "R4");
        pulse(3'b111); step(4);

        // R1/R6 single activity, short stretch
        led_a_mode = 4'h1; led_b_mode = 4'h2; stretch_sel = 2'b00;
        step(2);
        expect_run(1, T_S, 0, 1'b1, "R6"); expect_run(T_S + 1, T_S + 1, 0, 1'b0, "R6");
        expect_run(1, T_S + 1, 1, 1'b0, "R1");
        pulse(3'b001); step(6);
        expect_run(1, T_S, 1, 1'b1, "R1"); expect_run(T_S + 1, T_S + 1, 1, 1'b0, "R1");
        expect_run(1, T_S + 1, 0, 1'b0, "R1");
        pulse(3'b010); step(6);

        // R6 medium and long
        stretch_sel = 2'b01; step(1);
        expect_run(1, T_M, 0, 1'b1, "R6"); expect_run(T_M + 1, T_M + 1, 0, 1'b0, "R6");
        pulse(3'b001); step(T_M + 2);
        stretch_sel = 2'b10; step(1);
        expect_run(1, T_L, 0, 1'b1, "R6"); expect_run(T_L + 1, T_L + 1, 0, 1'b0, "R6");
        pulse(3'b001); step(T_L + 2);

        // R7 reserved select behaves as short
        stretch_sel = 2'b11; step(1);
        expect_run(1, T_S, 0, 1'b1, "R7"); expect_run(T_S + 1, T_S + 1, 0, 1'b0, "R7");
        pulse(3'b001); step(6);

        // R1 collision and tx-or-rx modes
        led_a_mode = 4'h3; led_b_mode = 4'h7; stretch_sel = 2'b00;
        step(2);
        expect_run(1, T_S, 0, 1'b1, "R1"); expect_run(T_S + 1, T_S + 1, 0, 1'b0, "R1");
        expect_run(1, T_S + 1, 1, 1'b0, "R1");
        pulse(3'b100); step(6);
        expect_run(1, T_S, 1, 1'b1, "R1"); expect_run(1, T_S + 1, 0, 1'b0, "R1");
        pulse(3'b010); step(6);

        // R5 stretching disabled
        stretch_en = 1'b0; led_a_mode = 4'h1;
        step(2);
        expect_run(1, 1, 0, 1'b1, "R5"); expect_run(2, 3, 0, 1'b0, "R5");
        pulse(3'b001); step(4);

        // R8 reload during a stretch
        stretch_en = 1'b1; stretch_sel = 2'b00;
        step(2);
        expect_run(1, 5, 0, 1'b1, "R8"); expect_run(6, 6, 0, 1'b0, "R8");
        pulse(3'b001); step(1); pulse(3'b001); step(6);

        // R9 combined modes, enable low, status true
        stretch_en = 1'b0; led_a_mode = 4'hC; led_b_mode = 4'hE;
        link_up = 1'b1; full_duplex = 1'b0;
        step(2);
        expect_run(1, T_S, 0, 1'b0, "R9"); expect_run(T_S + 1, T_S + 1, 0, 1'b1, "R9");
        expect_run(1, T_S, 1, 1'b1, "R9"); expect_run(T_S + 1, T_S + 1, 1, 1'b0, "R9");
        pulse(3'b110); step(6);
        // R9 status flipped
        link_up = 1'b0; full_duplex = 1'b1;
        step(2);
        expect_run(1, T_S, 0, 1'b1, "R9"); expect_run(T_S + 1, T_S + 1, 0, 1'b0, "R9");
        expect_run(1, T_S, 1, 1'b0, "R9"); expect_run(T_S + 1, T_S + 1, 1, 1'b1, "R9");
        pulse(3'b110); step(6);
        // R9 link with tx-or-rx
        led_a_mode = 4'hD; link_up = 1'b1;
        step(2);
        expect_run(1, T_S, 0, 1'b0, "R9"); expect_run(T_S + 1, T_S + 1, 0, 1'b1, "R9");
        pulse(3'b001); step(6);

        // R10 mode change discards a stretch
        stretch_en = 1'b1; stretch_sel = 2'b10; led_a_mode = 4'h1; led_b_mode = 4'h9;
        step(2);
        expect_run(1, 2, 0, 1'b1, "R10"); expect_run(3, 6, 0, 1'b0, "R10");
        pulse(3'b001); step(1);
        led_a_mode = 4'h7;
        step(6);

        // R2 blink rates
        led_a_mode = 4'hA; led_b_mode = 4'hB;
        measure_blink(0, H_F, "R2");
        measure_blink(1, H_S, "R2");

        // R11 reset mid-run
        led_a_mode = 4'h8; led_b_mode = 4'h8;
        step(2);
        rst_n = 1'b0;
        expect_run(1, 1, 0, 1'b0, "R11"); expect_run(1, 1, 1, 1'b0, "R11");
        step(2);
        rst_n = 1'b1;
        step(2);

        for (int k = 0; k < 50 && exp_q.size() != 0; k++) step(1);
        if (exp_q.size() != 0) chk(1'b0, "drain", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule